// File: doc/BRIEF.md
# Sorted Task Queue with Run-Time Key Selection

This block keeps a small set of task records in sorted order so that the best record is always visible at the head. It is a row of identical cells. Each cell holds one record, one key comparator and a next-value selector. The selector can keep the cell's record, take the record from the cell before it, take the record from the cell after it, or take the record being pushed. A push places the new record in its sorted slot in one clock cycle. A pop removes the head in one clock cycle.

A one-bit key selector picks what "best" means. With the selector low, the smallest time field wins. This gives earliest-deadline order for a ready queue, or earliest-wake-up order for a sleep queue that stores the activation time in the same field. With the selector high, the smallest priority number wins, which gives fixed-priority order. The selector is read at compare time, so it can be changed while the system runs. Records already stored are not re-sorted, so the selector should only be changed while the queue is empty.

Top module: `sysq_queue`

## Requirements
- R1: After reset, `empty` is 1 and `full` is 0.
- R2: With `key_sel` = 0, the head after each push or pop holds the stored record with the smallest `time` value. Successive pops return records in ascending `time` order. The effect of a push or pop is visible on the head outputs right after the next rising clock edge.
- R3: With `key_sel` = 1, the head holds the stored record with the smallest `prio` value. Successive pops return records in ascending `prio` order, whatever their `time` values.
- R4: Records with equal keys leave the queue in the order they were pushed. A new record is placed behind every stored record whose key equals its own.
- R5: A push while `full` is 1 and `pop` is 0 is refused. `push_drop` is 1 in that same cycle, and the stored records and flags stay unchanged.
- R6: A pop while `empty` is 1 has no effect. The queue stays empty.
- R7: A push and a pop in the same cycle remove the head and insert the new record in one step. This also works when the queue is full, and `full` stays 1 afterwards.
- R8: `full` is 1 exactly when DEPTH records are stored. `empty` is 1 exactly when no record is stored. Stored records always fill the cells from the head without gaps.
- R9: The period, priority, task number and status fields of a record come out at the head unchanged.
- R10: A push and a pop in the same cycle on an empty queue stores the pushed record, which becomes the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_sel | input | 1 | 0 = order by time field, 1 = order by priority number |
| push | input | 1 | Insert the record on the push_* inputs |
| push_time | input | TIME_W | Deadline or activation time of the new record |
| push_period | input | PER_W | Period of the new record |
| push_prio | input | PRIO_W | Priority number (lower is more urgent) |
| push_id | input | ID_W | Task number |
| push_stat | input | STAT_W | Status field |
| pop | input | 1 | Remove the head record |
| head_time | output | TIME_W | Time field of the head record |
| head_period | output | PER_W | Period of the head record |
| head_prio | output | PRIO_W | Priority number of the head record |
| head_id | output | ID_W | Task number of the head record |
| head_stat | output | STAT_W | Status of the head record |
| empty | output | 1 | No record stored |
| full | output | 1 | All cells occupied |
| push_drop | output | 1 | Push in this cycle is refused (combinational) |

## Verification
For a four-cell queue, every ordering of four distinct keys is pushed and then drained in both key modes. This shows that the insert position depends only on the key. The priority sweep pairs priorities with time values in the opposite order, so a comparator that reads the wrong field cannot pass. Runs of identical keys separate first-in-first-out tie handling from a stable but reversed placement. Long pseudo-random runs use a two-bit key range and mix push, pop, simultaneous push-pop, overfull pushes and empty pops. These runs exercise the shift-right, shift-left and combined-selection paths against an arithmetic model of the queue.

// File: rtl/sysq_pkg.sv
package sysq_pkg;
  parameter int TIME_W = 16;
  parameter int PER_W  = 16;
  parameter int PRIO_W = 8;
  parameter int ID_W   = 6;
  parameter int STAT_W = 2;
  localparam int KEY_W = (TIME_W > PRIO_W) ? TIME_W : PRIO_W;

  typedef struct packed {
    logic              vld;
    logic [TIME_W-1:0] tkey;
    logic [PER_W-1:0]  per;
    logic [PRIO_W-1:0] prio;
    logic [ID_W-1:0]   id;
    logic [STAT_W-1:0] stat;
  } sysq_ent_t;

  localparam sysq_ent_t ENT_NONE = '0;

  // Ordering key of a record under the current selection
  function automatic logic [KEY_W-1:0] sort_key(input sysq_ent_t e, input logic by_prio);
    sort_key = by_prio ? KEY_W'(e.prio) : KEY_W'(e.tkey);
  endfunction
endpackage

// File: rtl/sysq_flags.sv
module sysq_flags (
  input  logic push,
  input  logic pop,
  input  logic head_vld,
  input  logic tail_vld,
  output logic empty,
  output logic full,
  output logic pop_go,
  output logic push_go,
  output logic push_drop
);
  always_comb begin
    empty     = !head_vld;
    full      = tail_vld;
    pop_go    = pop && !empty;
    // a pop in the same cycle frees the slot a full queue needs
    push_go   = push && (!full || pop_go);
    push_drop = push && !push_go;
  end
endmodule

// File: rtl/sysq_cell.sv
module sysq_cell
  import sysq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      by_prio,
  input  logic      pop_go,
  input  logic      push_go,
  input  sysq_ent_t new_ent,
  input  sysq_ent_t right_q,
  input  sysq_ent_t left_view,
  input  logic      left_worse,
  output sysq_ent_t q,
  output sysq_ent_t view,
  output logic      worse
);
  sysq_ent_t nxt;
  logic      ld_en;

  // view: the record this cell would hold after a pop alone
  always_comb begin
    view  = pop_go ? right_q : q;
    // strict compare keeps equal keys in arrival order
    worse = !view.vld || (sort_key(view, by_prio) > sort_key(new_ent, by_prio));
  end

  always_comb begin
    nxt = view;
    if (push_go) begin
      if (worse && !left_worse) nxt = new_ent;
      else if (worse)           nxt = left_view;
    end
  end

  assign ld_en = pop_go || push_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= ENT_NONE;
    else if (ld_en) q <= nxt;
  end
endmodule

// File: rtl/sysq_queue.sv
module sysq_queue
  import sysq_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_sel,
  input  logic              push,
  input  logic [TIME_W-1:0] push_time,
  input  logic [PER_W-1:0]  push_period,
  input  logic [PRIO_W-1:0] push_prio,
  input  logic [ID_W-1:0]   push_id,
  input  logic [STAT_W-1:0] push_stat,
  input  logic              pop,
  output logic [TIME_W-1:0] head_time,
  output logic [PER_W-1:0]  head_period,
  output logic [PRIO_W-1:0] head_prio,
  output logic [ID_W-1:0]   head_id,
  output logic [STAT_W-1:0] head_stat,
  output logic              empty,
  output logic              full,
  output logic              push_drop
);
  localparam int LAST = DEPTH - 1;

  sysq_ent_t new_ent;
  sysq_ent_t q_a [DEPTH];
  sysq_ent_t v_a [DEPTH];
  logic      w_a [DEPTH];
  logic      pop_go, push_go;

  always_comb begin
    new_ent      = ENT_NONE;
    new_ent.vld  = 1'b1;
    new_ent.tkey = push_time;
    new_ent.per  = push_period;
    new_ent.prio = push_prio;
    new_ent.id   = push_id;
    new_ent.stat = push_stat;
  end

  sysq_flags u_flags (
    .push      (push),
    .pop       (pop),
    .head_vld  (q_a[0].vld),
    .tail_vld  (q_a[LAST].vld),
    .empty     (empty),
    .full      (full),
    .pop_go    (pop_go),
    .push_go   (push_go),
    .push_drop (push_drop)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    sysq_ent_t lv, rq;
    logic      lw;
    if (i == 0) begin : g_head
      assign lv = ENT_NONE;
      assign lw = 1'b0;
    end else begin : g_mid
      assign lv = v_a[i-1];
      assign lw = w_a[i-1];
    end
    if (i == LAST) begin : g_tail
      assign rq = ENT_NONE;
    end else begin : g_body
      assign rq = q_a[i+1];
    end

    sysq_cell u_cell (
      .clk        (clk),
      .rst_n      (rst_n),
      .by_prio    (key_sel),
      .pop_go     (pop_go),
      .push_go    (push_go),
      .new_ent    (new_ent),
      .right_q    (rq),
      .left_view  (lv),
      .left_worse (lw),
      .q          (q_a[i]),
      .view       (v_a[i]),
      .worse      (w_a[i])
    );

    if (i < LAST) begin : g_chk
      p_packed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        q_a[i+1].vld |-> q_a[i].vld)
        else $error("occupied cell behind a hole");
    end
  end

  assign head_time   = q_a[0].tkey;
  assign head_period = q_a[0].per;
  assign head_prio   = q_a[0].prio;
  assign head_id     = q_a[0].id;
  assign head_stat   = q_a[0].stat;

  p_drop_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    push_drop |=> full && q_a[0] == $past(q_a[0]))
    else $error("refused push disturbed the queue");

  p_empty_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> empty)
    else $error("pop on empty queue created a record");

  p_swap_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (full && pop && push) |=> full)
    else $error("push with pop on full queue lost occupancy");

  p_push_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && push) |=> !empty && head_id == $past(push_id))
    else $error("push into empty queue not at head");

  if (DEPTH > 1) begin : g_adv
    p_pop_adv_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && !empty) |=> q_a[0] == $past(q_a[1]))
      else $error("pop did not advance second record to head");
  end
endmodule

// File: tb/sim_sysq_queue.sv
`timescale 1ns/100ps
module sim_sysq_queue;
  localparam int D = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        key_sel = 1'b0;
  logic        push = 1'b0;
  logic        pop = 1'b0;
  logic [15:0] push_time = '0;
  logic [15:0] push_period = '0;
  logic [7:0]  push_prio = '0;
  logic [5:0]  push_id = '0;
  logic [1:0]  push_stat = '0;
  logic [15:0] head_time, head_period;
  logic [7:0]  head_prio;
  logic [5:0]  head_id;
  logic [1:0]  head_stat;
  logic        empty, full, push_drop;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // bench-side model of the queue contents
  int mt [D];
  int mper [D];
  int mpr [D];
  int mid [D];
  int mst [D];
  int mcnt = 0;

  always #2.5 clk = ~clk;

  sysq_queue #(.DEPTH(D)) u0 (
    .clk(clk), .rst_n(rst_n), .key_sel(key_sel), .push(push),
    .push_time(push_time), .push_period(push_period), .push_prio(push_prio),
    .push_id(push_id), .push_stat(push_stat), .pop(pop),
    .head_time(head_time), .head_period(head_period), .head_prio(head_prio),
    .head_id(head_id), .head_stat(head_stat),
    .empty(empty), .full(full), .push_drop(push_drop)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  function automatic int mkey(input int t, input int pr);
    return key_sel ? pr : t;
  endfunction

  task automatic model_step(input bit p, input bit q, input int t, input int per,
                            input int pr, input int id, input int st);
    bit popg, pushg;
    int pos;
    popg  = q && (mcnt > 0);
    pushg = p && ((mcnt < D) || popg);
    if (popg) begin
      for (int i = 0; i < D - 1; i++) begin
        mt[i] = mt[i+1]; mper[i] = mper[i+1]; mpr[i] = mpr[i+1];
        mid[i] = mid[i+1]; mst[i] = mst[i+1];
      end
      mcnt--;
    end
    if (pushg) begin
      pos = mcnt;
      for (int i = mcnt - 1; i >= 0; i--)
        if (mkey(mt[i], mpr[i]) > mkey(t, pr)) pos = i;
      for (int i = mcnt; i > pos; i--) begin
        mt[i] = mt[i-1]; mper[i] = mper[i-1]; mpr[i] = mpr[i-1];
        mid[i] = mid[i-1]; mst[i] = mst[i-1];
      end
      mt[pos] = t; mper[pos] = per; mpr[pos] = pr; mid[pos] = id; mst[pos] = st;
      mcnt++;
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic do_op(input bit p, input bit q, input int t, input int per,
                       input int pr, input int id, input int st, input string tag);
    bit exp_drop;
    push = p; pop = q;
    push_time = 16'(t); push_period = 16'(per); push_prio = 8'(pr);
    push_id = 6'(id); push_stat = 2'(st);
    #1;
    exp_drop = p && (mcnt == D) && !q;
    chk("R5 push_drop", int'(push_drop), int'(exp_drop));
    @(posedge clk);
    model_step(p, q, t, per, pr, id, st);
    @(negedge clk);
    push = 0; pop = 0;
    chk("R8 empty", int'(empty), int'(mcnt == 0));
    chk("R8 full", int'(full), int'(mcnt == D));
    if (mcnt > 0) begin
      chk({tag, " head_id"}, int'(head_id), mid[0]);
      chk({tag, " head_time"}, int'(head_time), mt[0]);
      chk({tag, " head_prio"}, int'(head_prio), mpr[0]);
      chk("R9 head_period", int'(head_period), mper[0]);
      chk("R9 head_stat", int'(head_stat), mst[0]);
    end
  endtask

  task automatic drain(input string tag);
    while (mcnt > 0) do_op(0, 1, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(5.0 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    bit [15:0] lf;
    int cnt4;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 empty after reset", int'(empty), 1);
    chk("R1 full after reset", int'(full), 0);

    // R6: pop on empty queue
    do_op(0, 1, 0, 0, 0, 0, 0, "R6");
    chk("R6 still empty", int'(empty), 1);

    // R2 / R3: every ordering of four distinct keys, both modes
    for (int m = 0; m < 2; m++) begin
      key_sel = m[0];
      for (int a = 0; a < 4; a++)
        for (int b = 0; b < 4; b++)
          for (int c = 0; c < 4; c++)
            for (int d = 0; d < 4; d++) begin
              if (a != b && a != c && a != d && b != c && b != d && c != d) begin
                int kk [4];
                kk[0] = a; kk[1] = b; kk[2] = c; kk[3] = d;
                for (int j = 0; j < 4; j++) begin
                  if (m == 0)
                    do_op(1, 0, kk[j] * 10 + 3, 100 + j, 7 - kk[j], j, kk[j] % 4, "R2");
                  else
                    do_op(1, 0, 40 - kk[j] * 10, 200 + j, kk[j] * 3, j, j, "R3");
                end
                do_op(1, 0, 0, 9, 0, 9, 1, "R5");
                chk("R5 full kept", int'(full), 1);
                drain(m == 0 ? "R2" : "R3");
              end
            end
    end

    // R4: equal keys stay in arrival order
    key_sel = 1'b0;
    for (int j = 0; j < 3; j++) do_op(1, 0, 5, 0, 0, j + 1, 0, "R4");
    do_op(1, 0, 2, 0, 0, 7, 0, "R4");
    drain("R4");
    key_sel = 1'b1;
    for (int j = 0; j < 4; j++) do_op(1, 0, 9 - j, 0, 3, j + 10, 2, "R4");
    drain("R4");

    // R7: push with pop on a full queue
    key_sel = 1'b0;
    for (int j = 0; j < 4; j++) do_op(1, 0, 20 + j * 5, 0, 0, j, 0, "R7");
    do_op(1, 1, 1, 0, 0, 40, 0, "R7");
    do_op(1, 1, 60, 0, 0, 41, 0, "R7");
    do_op(1, 1, 30, 0, 0, 42, 0, "R7");
    chk("R7 full after swaps", int'(full), 1);
    drain("R7");

    // R10: push with pop on an empty queue
    do_op(1, 1, 11, 5, 2, 33, 3, "R10");
    chk("R10 head stored", int'(head_id), 33);
    drain("R10");

    // pseudo-random mixed traffic with narrow keys, both modes
    lf = 16'hACE1;
    for (int m = 0; m < 6; m++) begin
      key_sel = m[0];
      for (int n = 0; n < 700; n++) begin
        bit p, q;
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        cnt4 = int'(lf[9:8]);
        p = (cnt4 != 0);
        q = lf[3] & lf[6];
        do_op(p, q, int'(lf[5:4]), int'(lf[15:10]), int'(lf[12:11]),
              int'(lf[14:9]), int'(lf[1:0]), key_sel ? "R3" : "R2");
      end
      drain(key_sel ? "R3" : "R2");
    end

    finish_run();
  end
endmodule